// File: doc/BRIEF.md
# Table-Driven YUV to ARGB Pixel Converter

This block converts a stream of YUV pixels into 32-bit ARGB pixels and packs them into 32-byte write beats, each with its own address. It does not multiply by a fixed matrix. Software first fills a small table with the fixed-point contribution of every 8-bit code to each output channel. For each pixel the block looks up six terms and adds the ones each channel needs. It then rounds the sum to the nearest integer and saturates it to 8 bits.

The pixels leave in lines. A line that does not fill its last beat is padded with zero bytes up to the 32-byte boundary. No other padding is emitted. The beat address starts at a base address captured during reset and rises by 32 for each beat. At the end of every line it also skips forward by a programmable step. A stalled output stalls the whole pipeline. When the output is not stalled, the block takes one pixel per cycle.

Top module: `yuv_argb_conv`

## Requirements
- R1: Software writes table entries through `tbl_we`/`tbl_sel`/`tbl_addr`/`tbl_wdata`. The `tbl_sel` codes are: 0 luma term, 1 first blue-difference term (U0), 2 second blue-difference term (U1), 3 first red-difference term (V0), 4 second red-difference term (V1), 5 alpha. Each region is indexed by the 8-bit code. The luma and alpha regions are indexed by `in_y`, the U regions by `in_u` and the V regions by `in_v`. A later write replaces the value used by later pixels.
- R2: Table terms are signed 16-bit numbers with 5 fractional bits. The channels are: red from luma + V0, green from luma + U0 + V1, and blue from luma + U1. Each channel is computed as (sum + 16) >> 5 with an arithmetic shift.
- R3: Each channel value is saturated. A negative result gives 0 and a result above 255 gives 255.
- R4: Alpha is the alpha-region entry, rounded and saturated by the same rule.
- R5: When the luma term read for a pixel is zero, red, green and blue are 0. Alpha is unaffected.
- R6: Pixel k (0..7) of a beat occupies `out_data[255-32k -: 32]`, with the bytes ordered alpha, red, green, blue from the most significant byte down.
- R7: A line of `line_w` pixels (`line_w` ≥ 1) produces ceil(line_w/8) beats. `out_last` marks the final beat of the line. The unused pixel slots of that beat are zero.
- R8: The first beat's address is the `base_addr` value present during reset. Each following beat within a line is 32 higher. The first beat of a new line is at the previous line's last beat address + 32 + `line_step`.
- R9: While `out_valid` is high and `out_ready` is low, the beat, its address and `out_last` hold and `in_ready` is low. No pixel is lost or repeated.
- R10: `line_done` is high exactly in the cycles where a beat with `out_last` is transferred (`out_valid && out_ready`).
- R11: After reset `out_valid` and `line_done` are low and `in_ready` is high.
- R12: Whenever `out_ready` is high, `in_ready` is high, so one pixel is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures `base_addr` |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 3 | Table region select |
| tbl_addr | input | 8 | Code index within the region |
| tbl_wdata | input | 16 | Signed 11.5 fixed-point term |
| line_w | input | WW | Pixels per line; held while a line is in flight |
| line_step | input | SW | Extra address skip applied after each line |
| base_addr | input | AW | Start address, sampled during reset |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high with `in_valid` |
| in_y | input | 8 | Luma code |
| in_u | input | 8 | Blue-difference code |
| in_v | input | 8 | Red-difference code |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Beat accepted when high with `out_valid` |
| out_data | output | 256 | Eight packed ARGB pixels |
| out_addr | output | AW | Byte address of the beat |
| out_last | output | 1 | Final beat of a line |
| line_done | output | 1 | Final beat of a line is transferred this cycle |

## Verification
The hardest case to reach combines two events at the output. A partial beat closes at a line end while the previous beat is still held by back-pressure, and that line end must also apply the address step. The bench makes this happen by switching `out_ready` at random on every cycle and by inserting random gaps in the input. It uses line widths that are and are not multiples of eight, so short final beats appear under stall. The table contents drive the sums past both saturation limits. Three full 256-pixel lines sweep every luma code, which includes the zero-luma entry.

// File: rtl/yuv_argb_conv.sv
module yuv_argb_conv #(
  parameter int AW = 32,
  parameter int WW = 12,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tbl_we,
  input  logic [2:0]    tbl_sel,
  input  logic [7:0]    tbl_addr,
  input  logic [15:0]   tbl_wdata,
  input  logic [WW-1:0] line_w,
  input  logic [SW-1:0] line_step,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_y,
  input  logic [7:0]    in_u,
  input  logic [7:0]    in_v,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [255:0]  out_data,
  output logic [AW-1:0] out_addr,
  output logic          out_last,
  output logic          line_done
);

  function automatic logic signed [17:0] ext(input logic [15:0] t);
    return $signed({{2{t[15]}}, t});
  endfunction

  function automatic logic [7:0] sat(input logic signed [17:0] s);
    logic signed [17:0] r;
    r = (s + 18'sd16) >>> 5;
    if (r < 0) return 8'd0;
    if (r > 18'sd255) return 8'hFF;
    return r[7:0];
  endfunction

  logic [15:0] tbl [6][256];
  logic [15:0] t_y1, t_u0, t_u1, t_v0, t_v1, t_a;
  logic          s1_v;
  logic [2:0]    slot;
  logic [WW-1:0] pcnt;
  logic [255:0]  acc;
  logic [AW-1:0] nxt_addr;
  logic          en, y0, pline_end, beat_end;
  logic [7:0]    a8, r8, g8, b8;
  logic [255:0]  acc_n;

  assign en        = !out_valid || out_ready;
  assign in_ready  = en;
  assign line_done = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (tbl_we && tbl_sel < 3'd6) tbl[tbl_sel][tbl_addr] <= tbl_wdata;
    if (en && in_valid) begin
      t_y1 <= tbl[0][in_y];
      t_u0 <= tbl[1][in_u];
      t_u1 <= tbl[2][in_u];
      t_v0 <= tbl[3][in_v];
      t_v1 <= tbl[4][in_v];
      t_a  <= tbl[5][in_y];
    end
  end

  assign y0 = (t_y1 == 16'd0);
  assign a8 = sat(ext(t_a));
  assign r8 = y0 ? 8'd0 : sat(ext(t_y1) + ext(t_v0));
  assign g8 = y0 ? 8'd0 : sat(ext(t_y1) + ext(t_u0) + ext(t_v1));
  assign b8 = y0 ? 8'd0 : sat(ext(t_y1) + ext(t_u1));

  assign pline_end = (pcnt == line_w - 1'b1);
  assign beat_end  = pline_end || (slot == 3'd7);
  assign acc_n = ((slot == 3'd0) ? 256'd0 : acc)
               | ({224'd0, a8, r8, g8, b8} << {3'd7 - slot, 5'd0});

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      slot      <= '0;
      pcnt      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_addr  <= base_addr;
      nxt_addr  <= base_addr;
    end else if (en) begin
      s1_v      <= in_valid;
      out_valid <= s1_v && beat_end;
      if (s1_v) begin
        acc  <= acc_n;
        pcnt <= pline_end ? '0 : pcnt + 1'b1;
        slot <= beat_end ? 3'd0 : slot + 3'd1;
        if (beat_end) begin
          out_data <= acc_n;
          out_addr <= nxt_addr;
          out_last <= pline_end;
          nxt_addr <= nxt_addr + AW'(32) + (pline_end ? AW'(line_step) : '0);
        end
      end
    end
  end

endmodule

module yuv_argb_conv_chk #(
  parameter int AW = 32,
  parameter int WW = 12,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [255:0]  out_data,
  input logic [AW-1:0] out_addr,
  input logic          out_last,
  input logic          line_done,
  input logic [WW-1:0] line_w,
  input logic [SW-1:0] line_step
);

  logic          have;
  logic [AW-1:0] nxt;
  logic [255:0]  padmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      have <= 1'b0;
      nxt  <= '0;
    end else if (out_valid && out_ready) begin
      have <= 1'b1;
      nxt  <= out_addr + AW'(32) + (out_last ? AW'(line_step) : '0);
    end
  end

  always_comb
    padmask = (line_w[2:0] == 3'd0) ? '0 : ({256{1'b1}} >> {line_w[2:0], 5'd0});

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_last));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_flow_r12: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    line_done |-> out_valid && out_ready && out_last);

  p_addr_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && have |-> out_addr == nxt);

  p_pad_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> (out_data & padmask) == 256'd0);

endmodule

bind yuv_argb_conv yuv_argb_conv_chk #(.AW(AW), .WW(WW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
  .out_last(out_last), .line_done(line_done), .line_w(line_w), .line_step(line_step)
);

// File: tb/yuv_argb_conv_bench.sv
module yuv_argb_conv_bench;
  localparam int AW = 32, WW = 12, SW = 16;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_sel = '0;
  logic [7:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [WW-1:0] line_w = 12'd1;
  logic [SW-1:0] line_step = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_last, line_done;
  logic [255:0] out_data;
  logic [AW-1:0] out_addr;

  always #4 clk = ~clk;

  yuv_argb_conv #(.AW(AW), .WW(WW), .SW(SW)) u_yuv_argb_conv (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .line_w(line_w), .line_step(line_step), .base_addr(BASE),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
    .out_last(out_last), .line_done(line_done)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic signed [15:0] bt [0:5][0:255];
  logic [255:0] exp_data [0:1023];
  logic [AW-1:0] exp_addr [0:1023];
  logic exp_last [0:1023];
  int ne = 0, nr = 0;
  logic [AW-1:0] ea = BASE;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clip(input int s);
    int r;
    r = (s + 16) >>> 5;
    if (r < 0) return 8'd0;
    if (r > 255) return 8'd255;
    return r[7:0];
  endfunction

  // R2 R3 R4 R5: expected pixel from the bench's own table copy
  function automatic logic [31:0] conv(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v);
    int y1, u0, u1, v0, v1;
    logic [7:0] a, r, g, b;
    y1 = bt[0][y]; u0 = bt[1][u]; u1 = bt[2][u]; v0 = bt[3][v]; v1 = bt[4][v];
    a = clip(int'(bt[5][y]));
    r = clip(y1 + v0); g = clip(y1 + u0 + v1); b = clip(y1 + u1);
    if (y1 == 0) begin r = 0; g = 0; b = 0; end
    return {a, r, g, b};
  endfunction

  task automatic twr(input int sel, input int adr, input int val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 3'(sel); tbl_addr = 8'(adr); tbl_wdata = 16'(val);
    bt[sel][adr] = 16'(val);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [7:0] py(int L, int k); return 8'((k + L * 3) % 256); endfunction
  function automatic logic [7:0] pu(int L, int k); return 8'((k * 7 + L * 50) % 256); endfunction
  function automatic logic [7:0] pv(int L, int k); return 8'((k * 13 + L * 90 + 5) % 256); endfunction

  // R6 R7 R8: expected beats, packing and addresses of one line
  task automatic plan_line(input int L, input int W, input int S);
    logic [255:0] acc;
    acc = '0;
    for (int k = 0; k < W; k++) begin
      int s;
      s = k % 8;
      if (s == 0) acc = '0;
      acc[255 - 32 * s -: 32] = conv(py(L, k), pu(L, k), pv(L, k));
      if (s == 7 || k == W - 1) begin
        exp_data[ne] = acc; exp_addr[ne] = ea; exp_last[ne] = (k == W - 1);
        ne++;
        ea = ea + 32 + ((k == W - 1) ? AW'(S) : '0);
      end
    end
  endtask

  task automatic send_line(input int L, input int W);
    for (int k = 0; k < W; k++) begin
      if (($urandom % 5) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_y = py(L, k); in_u = pu(L, k); in_v = pv(L, k);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic run_line(input int L, input int W, input int S);
    line_w = 12'(W); line_step = 16'(S);
    plan_line(L, W, S);
    send_line(L, W);
    while (nr < ne) @(negedge clk);
  endtask

  // output monitor: random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (rst) continue;
      out_ready = (($urandom % 3) != 0);
      #1;
      // R10
      check(line_done == (out_valid && out_ready && out_last), "R10", 256'(line_done), 256'(out_valid && out_ready && out_last));
      // R12
      if (out_ready) check(in_ready == 1'b1, "R12", 256'(in_ready), 256'd1);
      // R9
      if (out_valid && !out_ready) check(in_ready == 1'b0, "R9", 256'(in_ready), 256'd0);
      if (out_valid && out_ready) begin
        if (nr >= ne) check(1'b0, "R9 extra beat", out_data, '0);
        else begin
          check(out_data == exp_data[nr], "R2 R3 R4 R5 R6 R9 data", out_data, exp_data[nr]);
          check(out_addr == exp_addr[nr], "R8 addr", 256'(out_addr), 256'(exp_addr[nr]));
          check(out_last == exp_last[nr], "R7 last", 256'(out_last), 256'(exp_last[nr]));
          nr++;
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11
    check(out_valid == 1'b0, "R11 out_valid", 256'(out_valid), 256'd0);
    check(in_ready == 1'b1, "R11 in_ready", 256'(in_ready), 256'd1);
    check(line_done == 1'b0, "R11 line_done", 256'(line_done), 256'd0);
    // R1: table load; luma code 0 holds a zero term (R5), extremes reach both limits (R3)
    for (int i = 0; i < 256; i++) begin
      twr(0, i, (i == 0) ? 0 : i * 40 - 1000);
      twr(1, i, (i - 128) * -11);
      twr(2, i, (i - 128) * 57);
      twr(3, i, (i - 128) * 51);
      twr(4, i, (i - 128) * -26);
      twr(5, i, i * 37 - 500);
    end
    run_line(0, 1, 0);
    run_line(1, 8, 64);
    run_line(2, 9, 32);
    run_line(3, 256, 96);
    run_line(4, 256, 0);
    run_line(5, 256, 160);
    run_line(6, 3, 32);
    run_line(7, 17, 0);
    // R1: rewrite entries and confirm later pixels use the new values
    for (int i = 0; i < 32; i++) begin
      twr(5, (i + 24) % 256, 9000 - i * 300);
      twr(0, (i + 24) % 256, (i == 5) ? 0 : -200 + i * 500);
    end
    run_line(8, 24, 64);
    run_line(9, 15, 0);
    check(nr == ne, "R9 beat count", 256'(nr), 256'(ne));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", nr, ne);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule